// File: doc/BRIEF.md
# SPI Command Decoder with Register Access

This block is the serial command front end of a converter-style peripheral. It acts as an SPI slave in mode 1 (clock idles low, the master changes DIN on the rising edge and the slave samples it on the falling edge), MSB first. SCLK, chip select and DIN pass through a two-flop synchronizer into the system clock domain. Edges are detected there. Each received byte is decoded as a command.

One-byte commands raise one-cycle strobes: reset, start or stop for either of two converters, six calibration requests and two read-data requests. Two multibyte commands read or write a small byte-wide register file in bursts with an auto-incremented address. Conversion results arrive on a valid/ready stream and are captured into an output word, which a read-data command shifts out on MISO. The stream is back-pressured (ready low) while a register access is in progress, so a new result can never overwrite the output word in that window. The producer must hold `conv_valid` and `conv_data` steady until it sees ready high at a clock edge. A result is taken on every edge where both are high. Raising chip select at any point abandons the command in progress.

Top module: `spi_cmd_front`

## Requirements
- R1: DIN is shifted in on each synchronized falling SCLK edge while chip select is low, MSB first, and eight such edges form one byte.
- R2: Control opcodes ignore bit 0: 06h/07h pulse `cmd_reset`; 08h/09h pulse `cmd_start[0]`; 0Ah/0Bh pulse `cmd_stop[0]`; 0Ch/0Dh pulse `cmd_start[1]`; 0Eh/0Fh pulse `cmd_stop[1]`. Every strobe lasts exactly one clock, and one byte raises at most one strobe.
- R3: 12h/13h pulse `cmd_rdata[0]` and 14h/15h pulse `cmd_rdata[1]`. After either, until chip select rises, MISO presents the captured conversion word MSB first, advancing one bit per falling SCLK edge.
- R4: Calibration opcodes are decoded on all eight bits and pulse one bit of `cmd_cal`: 16h bit 0, 17h bit 1, 19h bit 2, 1Bh bit 3, 1Ch bit 4, 1Eh bit 5.
- R5: Every other opcode outside 20h–5Fh, including 00h, causes no strobe and no register change.
- R6: Write access is byte 010aaaaa (start address a), then byte xxxnnnnn (n+1 data bytes). Each data byte is committed to the current address only after its eighth bit, and the address then increments.
- R7: Read access is byte 001aaaaa, then the count byte as in R6. The register at address a appears on MISO MSB first during the third byte, and each later byte shows the next address, up to n+1 bytes.
- R8: Register addresses at or above `NREGS` read back as 00h, and writes to them change nothing.
- R9: Chip select high ends any command and clears the bit count. A partly received data byte is never written, and the next byte after chip select goes low again is aligned to a fresh boundary.
- R10: `conv_ready` is low from the cycle after the first byte of a register access until that access finishes or chip select rises. While it is low the captured conversion word does not change.
- R11: After reset all registers read 00h, all strobes are low, MISO is low and `conv_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master (mode 1) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| conv_valid | input | 1 | Conversion result offered |
| conv_data | input | CONV_W | Conversion result word |
| conv_ready | output | 1 | Result may be captured this cycle |
| cmd_reset | output | 1 | Reset request strobe |
| cmd_start | output | 2 | Start strobe per converter |
| cmd_stop | output | 2 | Stop strobe per converter |
| cmd_rdata | output | 2 | Read-data strobe per converter |
| cmd_cal | output | 6 | Calibration request strobes |
| cfg_regs | output | NREGS*8 | Register file contents, register i in bits 8i+7:8i |

## Verification
Two functions can meet in the same cycle: a conversion result arriving while a register write burst is under way. The bench opens a write access and offers a result once the count byte has been taken. It then checks that the result is held off (ready low, no transfer) while the data byte is still being shifted in. It checks that exactly one transfer happens once the access ends, that the written register holds the correct data, and that a following read-data command shifts out the held word bit-exactly.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_COUNT  = 2'd1,
    PH_DATA   = 2'd2
  } phase_t;

  typedef struct packed {
    logic       rst;
    logic [1:0] start;
    logic [1:0] stop;
    logic [1:0] rdata;
    logic [5:0] cal;
    logic       rd_acc;
    logic       wr_acc;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] b);
    op_dec_t d;
    d = '0;
    case (b[7:5])
      3'b001: d.rd_acc = 1'b1;
      3'b010: d.wr_acc = 1'b1;
      3'b000: begin
        case (b[4:1])
          4'h3: d.rst      = 1'b1;
          4'h4: d.start[0] = 1'b1;
          4'h5: d.stop[0]  = 1'b1;
          4'h6: d.start[1] = 1'b1;
          4'h7: d.stop[1]  = 1'b1;
          4'h9: d.rdata[0] = 1'b1;
          4'hA: d.rdata[1] = 1'b1;
          default: ;
        endcase
        case (b[4:0])
          5'h16: d.cal[0] = 1'b1;
          5'h17: d.cal[1] = 1'b1;
          5'h19: d.cal[2] = 1'b1;
          5'h1B: d.cal[3] = 1'b1;
          5'h1C: d.cal[4] = 1'b1;
          5'h1E: d.cal[5] = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       smp,
  input  logic       din,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  logic [2:0] bitcnt;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!sel) begin
        bitcnt <= '0;
      end else if (smp) begin
        sh     <= {sh[5:0], din};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_q   <= {sh, din};
        end
      end
    end
  end

  // R9
  cs_clears_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> bitcnt == 3'd0);

  // R1
  byte_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(smp));
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile #(
  parameter int NREGS  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [7:0]          wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [7:0]          rdata,
  output logic [NREGS*8-1:0]  flat
);
  logic [7:0] mem [NREGS];

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                            mem[i] <= '0;
        else if (we && waddr == ADDR_W'(i))    mem[i] <= wdata;
      assign flat[i*8 +: 8] = mem[i];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (raddr == ADDR_W'(i)) rdata = mem[i];
  end

  // R8
  oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(waddr) >= NREGS) |=> $stable(flat));
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
  import spi_cmd_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int CONV_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic                conv_valid,
  input  logic [CONV_W-1:0]   conv_data,
  output logic                conv_ready,
  output logic                cmd_reset,
  output logic [1:0]          cmd_start,
  output logic [1:0]          cmd_stop,
  output logic [1:0]          cmd_rdata,
  output logic [5:0]          cmd_cal,
  output logic [NREGS*8-1:0]  cfg_regs
);
  localparam int CNT_W = ADDR_W;

  logic sclk_s, cs_s, mosi_s, sclk_d;
  logic fall, sel;
  logic byte_vld;
  logic [7:0] byte_q;
  op_dec_t dec;

  phase_t              ph;
  logic                is_wr;
  logic [ADDR_W-1:0]   ptr;
  logic [CNT_W-1:0]    cnt;
  logic [7:0]          tx;
  logic                conv_rd;
  logic [CONV_W-1:0]   conv_sh;

  logic                rf_we;
  logic [ADDR_W-1:0]   rf_raddr;
  logic [7:0]          rf_rdata;

  spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk, spi_cs_n, spi_mosi}),
    .q     ({sclk_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;

  assign fall = sclk_d & ~sclk_s;
  assign sel  = ~cs_s;

  spi_byte_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .smp      (fall),
    .din      (mosi_s),
    .byte_vld (byte_vld),
    .byte_q   (byte_q)
  );

  assign dec = decode_op(byte_q);

  assign rf_we    = sel && byte_vld && ph == PH_DATA && is_wr;
  assign rf_raddr = (ph == PH_DATA) ? ptr + ADDR_W'(1) : ptr;

  cmd_regfile #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (ptr),
    .wdata (byte_q),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .flat  (cfg_regs)
  );

  assign conv_ready = (ph == PH_OPCODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_OPCODE;
      is_wr     <= 1'b0;
      ptr       <= '0;
      cnt       <= '0;
      tx        <= '0;
      conv_rd   <= 1'b0;
      conv_sh   <= '0;
      cmd_reset <= 1'b0;
      cmd_start <= '0;
      cmd_stop  <= '0;
      cmd_rdata <= '0;
      cmd_cal   <= '0;
    end else begin
      cmd_reset <= 1'b0;
      cmd_start <= '0;
      cmd_stop  <= '0;
      cmd_rdata <= '0;
      cmd_cal   <= '0;
      if (!sel) begin
        ph      <= PH_OPCODE;
        conv_rd <= 1'b0;
      end else begin
        if (fall) begin
          if (ph == PH_DATA && !is_wr) tx <= {tx[6:0], 1'b0};
          if (conv_rd) conv_sh <= conv_sh << 1;
        end
        if (byte_vld) begin
          case (ph)
            PH_OPCODE: begin
              cmd_reset <= dec.rst;
              cmd_start <= dec.start;
              cmd_stop  <= dec.stop;
              cmd_rdata <= dec.rdata;
              cmd_cal   <= dec.cal;
              if (dec.rd_acc || dec.wr_acc) begin
                ph      <= PH_COUNT;
                is_wr   <= dec.wr_acc;
                ptr     <= byte_q[ADDR_W-1:0];
                conv_rd <= 1'b0;
              end else if (|dec.rdata) begin
                conv_rd <= 1'b1;
              end
            end
            PH_COUNT: begin
              cnt <= byte_q[CNT_W-1:0];
              ph  <= PH_DATA;
              tx  <= rf_rdata;
            end
            PH_DATA: begin
              ptr <= ptr + ADDR_W'(1);
              tx  <= rf_rdata;
              if (cnt == '0) ph  <= PH_OPCODE;
              else           cnt <= cnt - CNT_W'(1);
            end
            default: ph <= PH_OPCODE;
          endcase
        end
      end
      if (conv_valid && conv_ready) conv_sh <= conv_data;
    end
  end

  always_comb begin
    if (ph == PH_DATA && !is_wr) spi_miso = tx[7];
    else if (conv_rd)            spi_miso = conv_sh[CONV_W-1];
    else                         spi_miso = 1'b0;
  end

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_reset, cmd_start, cmd_stop, cmd_rdata, cmd_cal}));

  // R2
  reset_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !cmd_reset);

  // R10
  busy_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_OPCODE) |=> $stable(conv_sh));

  // R9
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ph == PH_OPCODE);

  // R6
  write_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> ptr == $past(ptr) + ADDR_W'(1));
endmodule

// File: tb/sim_spi_cmd_front.sv
module sim_spi_cmd_front;
  localparam int NREGS  = 8;
  localparam int CONV_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic conv_valid = 1'b0;
  logic [CONV_W-1:0] conv_data = '0;
  logic miso, conv_ready, cmd_reset;
  logic [1:0] cmd_start, cmd_stop, cmd_rdata;
  logic [5:0] cmd_cal;
  logic [NREGS*8-1:0] cfg_regs;

  spi_cmd_front #(.NREGS(NREGS), .CONV_W(CONV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .conv_valid(conv_valid),
    .conv_data(conv_data), .conv_ready(conv_ready), .cmd_reset(cmd_reset),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_rdata(cmd_rdata),
    .cmd_cal(cmd_cal), .cfg_regs(cfg_regs)
  );

  logic [12:0] stb;
  assign stb = {cmd_cal, cmd_rdata, cmd_stop, cmd_start, cmd_reset};

  int unsigned scnt [13];
  int unsigned acc_cnt = 0;
  always @(posedge clk) begin
    for (int i = 0; i < 13; i++) if (stb[i]) scnt[i]++;
    if (conv_valid && conv_ready) acc_cnt++;
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] t, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b1; mosi = t[7-i];
      #100;
      r[7-i] = miso;
      sclk = 1'b0;
      #100;
    end
  endtask

  task automatic cs_begin(); cs_n = 1'b0; #100; endtask
  task automatic cs_end();   #100; cs_n = 1'b1; #300; endtask

  task automatic push(input logic [CONV_W-1:0] w);
    @(negedge clk);
    conv_valid = 1'b1; conv_data = w;
    @(negedge clk);
    while (!conv_ready) @(negedge clk);
    @(negedge clk);
    conv_valid = 1'b0;
    #5;
  endtask

  function automatic logic [12:0] exp_mask(input logic [7:0] op);
    logic [12:0] m;
    m = '0;
    if (op[7:5] == 3'b000) begin
      case (op[4:1])
        4'h3: m[0] = 1'b1;
        4'h4: m[1] = 1'b1;
        4'h6: m[2] = 1'b1;
        4'h5: m[3] = 1'b1;
        4'h7: m[4] = 1'b1;
        4'h9: m[5] = 1'b1;
        4'hA: m[6] = 1'b1;
        default: ;
      endcase
      case (op[4:0])
        5'h16: m[7]  = 1'b1;
        5'h17: m[8]  = 1'b1;
        5'h19: m[9]  = 1'b1;
        5'h1B: m[10] = 1'b1;
        5'h1C: m[11] = 1'b1;
        5'h1E: m[12] = 1'b1;
        default: ;
      endcase
    end
    return m;
  endfunction

  function automatic string op_tag(input logic [7:0] op);
    logic [12:0] m;
    m = exp_mask(op);
    if (|m[4:0])  return "R2 control opcode";
    if (|m[6:5])  return "R3 read-data opcode";
    if (|m[12:7]) return "R4 calibration opcode";
    if (op >= 8'h20 && op < 8'h60) return "R9 access aborted after opcode";
    return "R5 ignored opcode";
  endfunction

  function automatic logic [7:0] wval(input int a);
    return 8'((a * 37 + 5) & 8'hFF);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int unsigned base [13];
    logic [12:0] act;
    bit multi;
    logic [CONV_W-1:0] got;
    int unsigned acc0;

    for (int i = 0; i < 13; i++) scnt[i] = 0;
    #105;
    rst_n = 1'b1;
    #200;

    // R11 reset state
    check(miso == 1'b0, "R11 miso after reset", miso, 0);
    check(conv_ready == 1'b1, "R11 ready after reset", conv_ready, 1);
    check(stb == '0, "R11 strobes after reset", stb, 0);
    check(cfg_regs == '0, "R11 registers after reset", cfg_regs, 0);

    // R2 R3 R4 R5 R9: sweep every opcode as a lone byte
    for (int op = 0; op < 256; op++) begin
      for (int i = 0; i < 13; i++) base[i] = scnt[i];
      cs_begin();
      xfer(8'(op), 8, r);
      cs_end();
      act = '0; multi = 1'b0;
      for (int i = 0; i < 13; i++) begin
        if (scnt[i] - base[i] == 1) act[i] = 1'b1;
        if (scnt[i] - base[i] > 1)  multi = 1'b1;
      end
      check(act == exp_mask(8'(op)) && !multi && cfg_regs == '0,
            op_tag(8'(op)), {op[7:0], 3'b0, act}, {op[7:0], 3'b0, exp_mask(8'(op))});
    end

    // R2 R4 back-to-back commands under one chip select
    for (int i = 0; i < 13; i++) base[i] = scnt[i];
    cs_begin();
    xfer(8'h09, 8, r); xfer(8'h0A, 8, r); xfer(8'h17, 8, r); xfer(8'h0E, 8, r);
    cs_end();
    check(scnt[1] - base[1] == 1 && scnt[3] - base[3] == 1 &&
          scnt[8] - base[8] == 1 && scnt[4] - base[4] == 1,
          "R2 R4 chained commands", scnt[1] - base[1], 1);

    // R6 R1 burst write from address 0 past the end
    cs_begin();
    xfer(8'h40, 8, r);
    xfer(8'(NREGS + 1), 8, r);
    check(conv_ready == 1'b0, "R10 ready during write burst", conv_ready, 0);
    for (int a = 0; a < NREGS + 2; a++) xfer(wval(a), 8, r);
    cs_end();
    for (int a = 0; a < NREGS; a++)
      check(cfg_regs[a*8 +: 8] == wval(a), "R6 burst write", cfg_regs[a*8 +: 8], wval(a));

    // R7 R8 burst read from 0 past the end
    cs_begin();
    xfer(8'h20, 8, r);
    xfer(8'(NREGS + 1), 8, r);
    for (int a = 0; a < NREGS + 2; a++) begin
      xfer(8'h00, 8, r);
      if (a < NREGS) check(r == wval(a), "R7 burst read", r, wval(a));
      else           check(r == 8'h00, "R8 out-of-range read", r, 0);
    end
    cs_end();

    // R7 read from a middle address
    cs_begin();
    xfer(8'h23, 8, r); xfer(8'h01, 8, r);
    xfer(8'h00, 8, r); check(r == wval(3), "R7 read at offset", r, wval(3));
    xfer(8'h00, 8, r); check(r == wval(4), "R7 read increments", r, wval(4));
    cs_end();

    // R8 write straddling the end
    cs_begin();
    xfer(8'h46, 8, r); xfer(8'h03, 8, r);
    xfer(8'hA1, 8, r); xfer(8'hB2, 8, r); xfer(8'hC3, 8, r); xfer(8'hD4, 8, r);
    cs_end();
    check(cfg_regs[6*8 +: 8] == 8'hA1 && cfg_regs[7*8 +: 8] == 8'hB2,
          "R8 in-range part of straddling write", cfg_regs[7*8 +: 16], 16'hB2A1);
    check(cfg_regs[0 +: 48] == {wval(5), wval(4), wval(3), wval(2), wval(1), wval(0)},
          "R8 straddling write leaves others", cfg_regs[0 +: 48], 0);

    // R9 abort mid data byte, then realignment
    cs_begin();
    xfer(8'h42, 8, r); xfer(8'h00, 8, r); xfer(8'hA5, 4, r);
    cs_end();
    check(cfg_regs[2*8 +: 8] == wval(2), "R9 partial byte not written", cfg_regs[2*8 +: 8], wval(2));
    for (int i = 0; i < 13; i++) base[i] = scnt[i];
    cs_begin(); xfer(8'h08, 8, r); cs_end();
    check(scnt[1] - base[1] == 1, "R9 realigned after abort", scnt[1] - base[1], 1);

    // R10 result offered during a write access
    acc0 = acc_cnt;
    cs_begin();
    xfer(8'h41, 8, r); xfer(8'h00, 8, r);
    fork
      push(24'hC35A96);
      begin
        #400;
        check(conv_ready == 1'b0, "R10 ready held low", conv_ready, 0);
        check(acc_cnt == acc0, "R10 no transfer while busy", acc_cnt - acc0, 0);
        xfer(8'h3C, 8, r);
      end
    join
    cs_end();
    check(acc_cnt == acc0 + 1, "R10 single transfer after access", acc_cnt - acc0, 1);
    check(cfg_regs[1*8 +: 8] == 8'h3C, "R6 write beside collision", cfg_regs[1*8 +: 8], 8'h3C);

    // R3 read held word via converter-1 read
    cs_begin();
    xfer(8'h13, 8, r);
    got = '0;
    for (int b = 0; b < 3; b++) begin xfer(8'h00, 8, r); got = {got[15:0], r}; end
    cs_end();
    check(got == 24'hC35A96, "R3 word after collision", got, 24'hC35A96);

    // R3 converter-2 read of a freshly pushed word
    push(24'h1E2D4B);
    for (int i = 0; i < 13; i++) base[i] = scnt[i];
    cs_begin();
    xfer(8'h14, 8, r);
    got = '0;
    for (int b = 0; b < 3; b++) begin xfer(8'h00, 8, r); got = {got[15:0], r}; end
    cs_end();
    check(got == 24'h1E2D4B, "R3 word via second read opcode", got, 24'h1E2D4B);
    check(scnt[6] - base[6] == 1, "R3 second read strobe", scnt[6] - base[6], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule